// File: doc/BRIEF.md
# Dispatch Group Slot Checker

This block keeps count of how many of the five issue slots in the current dispatch group are taken. It judges each candidate instruction from its decoded attributes and returns one of three verdicts. The instruction may join the group now. It may have to wait for the next group. Or it may join only after a filler no-op, because joining directly would cause a pipeline flush. A scheduler presents a candidate on every cycle and reads the verdict one cycle later. It pulses `issue` when it commits the candidate, or `advance` when a slot is spent on an empty cycle.

The candidate's attributes are:
- its execution unit class;
- whether it must lead a group or must occupy a group alone;
- whether the decoder splits it into two operations;
- whether it writes the count register;
- whether it branches indirectly through that register;
- whether it is a load or a store.

A companion block compares addresses and delivers the result as `addr_hit`. This block only records whether a store has already joined the current group.

Top module: `dgroup_checker`

## Requirements
- R1: While `rst_n` is low and after it is released, `verdict` is 00, `slots_used` is 0 and `adv_error` is 0. An empty group starts.
- R2: A candidate flagged lead-only or alone-only (unit not 0) gets verdict 01 (wait) when `slots_used` is not 0. At `slots_used` 0 these flags do not cause a wait.
- R3: A split candidate gets 01 when `slots_used` is above 2. When issued, a split candidate consumes two slots.
- R4: A candidate of unit 1 to 5 gets 01 when `slots_used` is 4. A branch (unit 7) at 4 slots gets 00.
- R5: A condition-register candidate (unit 6) gets 01 when `slots_used` is 2 or more, and 00 below 2.
- R6: Issuing a branch or an alone-only candidate closes the group. Closing sets `slots_used` to 0 and forgets any count-register write and any store seen in the group.
- R7: After a count-register write has issued in the group, a candidate with `br_cnt` set gets 10 (needs a filler). In a new group it gets 00.
- R8: A load with `addr_hit` set gets 10 only when a store has issued in the current group. With no store, or with `addr_hit` clear, it gets 00.
- R9: A lone `advance` pulse adds one slot. When the count reaches five, the group closes and `slots_used` returns to 0.
- R10: When `issue` and `advance` coincide, the advance counts after the issue. If the issue alone filled the group, the advance is illegal: `adv_error` is set and stays set until reset. The group still closes.
- R11: A unit-0 (pseudo) candidate always gets 00, and issuing it changes no state.
- R12: `verdict` is registered: it is valid one cycle after the candidate is presented and judges the state from before any issue in that cycle. The codes are 00 join, 01 wait, 10 filler. Wait takes precedence over filler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_cls | input | 3 | Unit class: 0 pseudo, 1 fixed, 2 load/store, 3 float, 4 vector, 5 permute, 6 condition register, 7 branch |
| lead_only | input | 1 | Candidate must be first in a group |
| alone_only | input | 1 | Candidate must fill a group by itself |
| split_op | input | 1 | Decoder splits candidate into two operations |
| wr_cnt | input | 1 | Candidate writes the count register |
| br_cnt | input | 1 | Candidate branches through the count register |
| is_load | input | 1 | Candidate reads memory |
| is_store | input | 1 | Candidate writes memory |
| addr_hit | input | 1 | Load address overlaps an earlier store (from companion) |
| issue | input | 1 | Commit the presented candidate to the group |
| advance | input | 1 | Spend one slot on an empty cycle |
| verdict | output | 2 | Registered result: 00 join, 01 wait, 10 filler |
| slots_used | output | 3 | Slots taken in the current group |
| adv_error | output | 1 | Sticky flag for an advance into a full group |

## Verification
The bench builds the block with its default parameters: a five-slot group, condition-register candidates limited to the first two slots, and split candidates refused above two slots. With those values, every slot count from 0 to 4 can be reached within a few vectors. So the bench can probe every boundary: the last-slot branch rule, the split limit at three, and the condition-register limit at two. It can also reach a coinciding issue and advance that overflows the group, which is the only way to set the error flag.

// File: rtl/dgc_pkg.sv
package dgc_pkg;

  typedef enum logic [2:0] {
    U_PSEUDO = 3'd0,
    U_FIX    = 3'd1,
    U_LDST   = 3'd2,
    U_FLT    = 3'd3,
    U_VEC    = 3'd4,
    U_VPRM   = 3'd5,
    U_COND   = 3'd6,
    U_BRANCH = 3'd7
  } unit_e;

  typedef enum logic [1:0] {
    RES_OK    = 2'b00,
    RES_STALL = 2'b01,
    RES_FILL  = 2'b10
  } res_e;

  typedef struct packed {
    unit_e unit;
    logic  lead_only;
    logic  alone_only;
    logic  split_op;
    logic  wr_cnt;
    logic  br_cnt;
    logic  is_load;
    logic  is_store;
    logic  addr_hit;
  } attr_t;

endpackage

// File: rtl/dgc_rules.sv
module dgc_rules
  import dgc_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int COND_SLOTS  = 2,
  parameter int SPLIT_MAX   = 2,
  parameter int CW          = 3
) (
  input  attr_t         cand,
  input  logic [CW-1:0] used,
  input  logic          cnt_armed,
  input  logic          store_seen,
  output res_e          verdict
);

  localparam logic [CW-1:0] LAST_SLOT = CW'(GROUP_SLOTS - 1);
  localparam logic [CW-1:0] COND_LIM  = CW'(COND_SLOTS);
  localparam logic [CW-1:0] SPLIT_LIM = CW'(SPLIT_MAX);

  logic stall;
  logic fill;

  always_comb begin
    stall = 1'b0;
    if ((cand.lead_only || cand.alone_only) && (used != '0)) stall = 1'b1;
    if (cand.split_op && (used > SPLIT_LIM)) stall = 1'b1;
    case (cand.unit)
      U_COND:   if (used >= COND_LIM) stall = 1'b1;
      U_BRANCH: ;
      default:  if (used == LAST_SLOT) stall = 1'b1;
    endcase
  end

  always_comb begin
    fill = (cnt_armed && cand.br_cnt) ||
           (cand.is_load && store_seen && cand.addr_hit);
  end

  always_comb begin
    verdict = RES_OK;
    if (cand.unit != U_PSEUDO) begin
      if (stall)     verdict = RES_STALL;
      else if (fill) verdict = RES_FILL;
    end
  end

endmodule

// File: rtl/dgc_slot_tracker.sv
module dgc_slot_tracker
  import dgc_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int CW          = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          advance,
  input  attr_t         cand,
  output logic [CW-1:0] used_q,
  output logic          cnt_armed_q,
  output logic          store_seen_q,
  output logic          err_q
);

  localparam logic [CW:0]   FULL_W  = (CW+1)'(GROUP_SLOTS);
  localparam logic [CW:0]   LAST_W  = (CW+1)'(GROUP_SLOTS - 1);
  localparam logic [CW:0]   ONE_W   = (CW+1)'(1);
  localparam logic [CW-1:0] LAST_N  = CW'(GROUP_SLOTS - 1);

  logic          real_iss;
  logic          closer;
  logic [CW:0]   after_iss;
  logic [CW:0]   after_all;
  logic          full_iss;
  logic          bad_adv;
  logic          close_grp;
  logic          upd_en;
  logic [CW-1:0] used_d;
  logic          armed_d;
  logic          store_d;
  logic          err_d;

  always_comb begin
    real_iss  = issue && (cand.unit != U_PSEUDO);
    closer    = (cand.unit == U_BRANCH) || cand.alone_only;
    after_iss = {1'b0, used_q};
    if (real_iss) begin
      if (closer) after_iss = LAST_W;
      after_iss = after_iss + ONE_W + {{CW{1'b0}}, cand.split_op};
    end
    full_iss  = (after_iss >= FULL_W);
    bad_adv   = advance && full_iss;
    after_all = after_iss + {{CW{1'b0}}, (advance && !full_iss)};
    close_grp = (after_all >= FULL_W);
    upd_en    = issue || advance;
  end

  always_comb begin
    if (close_grp) begin
      used_d  = '0;
      armed_d = 1'b0;
      store_d = 1'b0;
    end else begin
      used_d  = after_all[CW-1:0];
      armed_d = cnt_armed_q  || (real_iss && cand.wr_cnt);
      store_d = store_seen_q || (real_iss && cand.is_store);
    end
    err_d = err_q || bad_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q       <= '0;
      cnt_armed_q  <= 1'b0;
      store_seen_q <= 1'b0;
      err_q        <= 1'b0;
    end else if (upd_en) begin
      used_q       <= used_d;
      cnt_armed_q  <= armed_d;
      store_seen_q <= store_d;
      err_q        <= err_d;
    end
  end

  // R6: a committed branch always leaves an empty group behind
  p_branch_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && cand.unit == U_BRANCH) |=> (used_q == '0 && !cnt_armed_q && !store_seen_q));

  // R9: a lone advance below the last slot moves the count by exactly one
  p_adv_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !issue && used_q < LAST_N) |=> (used_q == $past(used_q) + CW'(1)));

  // R10: the error flag never clears outside reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R11: committing a pseudo candidate leaves the slot count untouched
  p_pseudo_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !advance && cand.unit == U_PSEUDO) |=> $stable(used_q));

endmodule

// File: rtl/dgroup_checker.sv
module dgroup_checker
  import dgc_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int COND_SLOTS  = 2,
  parameter int SPLIT_MAX   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] unit_cls,
  input  logic       lead_only,
  input  logic       alone_only,
  input  logic       split_op,
  input  logic       wr_cnt,
  input  logic       br_cnt,
  input  logic       is_load,
  input  logic       is_store,
  input  logic       addr_hit,
  input  logic       issue,
  input  logic       advance,
  output logic [1:0] verdict,
  output logic [2:0] slots_used,
  output logic       adv_error
);

  localparam int CW = $clog2(GROUP_SLOTS + 2);

  attr_t         cand;
  logic [CW-1:0] used;
  logic          cnt_armed;
  logic          store_seen;
  logic          err;
  res_e          verdict_d;
  res_e          verdict_q;

  always_comb begin
    cand.unit       = unit_e'(unit_cls);
    cand.lead_only  = lead_only;
    cand.alone_only = alone_only;
    cand.split_op   = split_op;
    cand.wr_cnt     = wr_cnt;
    cand.br_cnt     = br_cnt;
    cand.is_load    = is_load;
    cand.is_store   = is_store;
    cand.addr_hit   = addr_hit;
  end

  dgc_rules #(
    .GROUP_SLOTS(GROUP_SLOTS),
    .COND_SLOTS (COND_SLOTS),
    .SPLIT_MAX  (SPLIT_MAX),
    .CW         (CW)
  ) rules_i (
    .cand      (cand),
    .used      (used),
    .cnt_armed (cnt_armed),
    .store_seen(store_seen),
    .verdict   (verdict_d)
  );

  dgc_slot_tracker #(
    .GROUP_SLOTS(GROUP_SLOTS),
    .CW         (CW)
  ) track_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (issue),
    .advance     (advance),
    .cand        (cand),
    .used_q      (used),
    .cnt_armed_q (cnt_armed),
    .store_seen_q(store_seen),
    .err_q       (err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) verdict_q <= RES_OK;
    else        verdict_q <= verdict_d;
  end

  assign verdict    = verdict_q;
  assign slots_used = 3'(used);
  assign adv_error  = err;

  // R2: a lead-only candidate outside slot zero must wait
  p_lead_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cand.unit != U_PSEUDO && lead_only && used != '0) |=> (verdict_q == RES_STALL));

  // R11: pseudo candidates are always accepted
  p_pseudo_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cand.unit == U_PSEUDO) |=> (verdict_q == RES_OK));

  // R12: the verdict is always one of the three defined codes
  p_code_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_q != 2'b11);

endmodule

// File: tb/dgroup_checker_tb_top.sv
module dgroup_checker_tb_top;

  logic       clk;
  logic       rst_n;
  logic [2:0] unit_cls;
  logic       lead_only, alone_only, split_op, wr_cnt, br_cnt;
  logic       is_load, is_store, addr_hit, issue, advance;
  logic [1:0] verdict;
  logic [2:0] slots_used;
  logic       adv_error;

  int total = 0;
  int bad   = 0;

  dgroup_checker dut_i (
    .clk(clk), .rst_n(rst_n), .unit_cls(unit_cls),
    .lead_only(lead_only), .alone_only(alone_only), .split_op(split_op),
    .wr_cnt(wr_cnt), .br_cnt(br_cnt), .is_load(is_load), .is_store(is_store),
    .addr_hit(addr_hit), .issue(issue), .advance(advance),
    .verdict(verdict), .slots_used(slots_used), .adv_error(adv_error)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Vector: [23:20] req, [19:17] unit,
  // [16:7] lead alone split wrcnt brcnt load store hit issue adv,
  // [6:5] verdict, [4:2] slots, [1] err, [0] spare
  localparam int NV = 33;
  localparam logic [23:0] VEC [NV] = '{
    {4'd12, 3'd1, 10'b0000000010, 2'b00, 3'd1, 1'b0, 1'b0}, // R12 fixed issue
    {4'd12, 3'd1, 10'b0000000010, 2'b00, 3'd2, 1'b0, 1'b0}, // R12
    {4'd5,  3'd6, 10'b0000000000, 2'b01, 3'd2, 1'b0, 1'b0}, // R5 cond at 2
    {4'd2,  3'd1, 10'b1000000000, 2'b01, 3'd2, 1'b0, 1'b0}, // R2 lead at 2
    {4'd3,  3'd1, 10'b0010000010, 2'b00, 3'd4, 1'b0, 1'b0}, // R3 split adds 2
    {4'd4,  3'd1, 10'b0000000000, 2'b01, 3'd4, 1'b0, 1'b0}, // R4 last slot
    {4'd3,  3'd1, 10'b0010000000, 2'b01, 3'd4, 1'b0, 1'b0}, // R3 split at 4
    {4'd4,  3'd7, 10'b0000000010, 2'b00, 3'd0, 1'b0, 1'b0}, // R4 branch at 4
    {4'd5,  3'd6, 10'b0000000010, 2'b00, 3'd1, 1'b0, 1'b0}, // R5 cond at 0
    {4'd5,  3'd6, 10'b0000000010, 2'b00, 3'd2, 1'b0, 1'b0}, // R5 cond at 1
    {4'd6,  3'd7, 10'b0000000010, 2'b00, 3'd0, 1'b0, 1'b0}, // R6 branch closes
    {4'd7,  3'd1, 10'b0001000010, 2'b00, 3'd1, 1'b0, 1'b0}, // R7 count write
    {4'd7,  3'd7, 10'b0000100000, 2'b10, 3'd1, 1'b0, 1'b0}, // R7 filler
    {4'd11, 3'd0, 10'b0110000010, 2'b00, 3'd1, 1'b0, 1'b0}, // R11 pseudo issue
    {4'd9,  3'd0, 10'b0000000001, 2'b00, 3'd2, 1'b0, 1'b0}, // R9 advance
    {4'd7,  3'd7, 10'b0000100010, 2'b10, 3'd0, 1'b0, 1'b0}, // R7 issued anyway
    {4'd7,  3'd7, 10'b0000100000, 2'b00, 3'd0, 1'b0, 1'b0}, // R7 new group
    {4'd8,  3'd2, 10'b0000001010, 2'b00, 3'd1, 1'b0, 1'b0}, // R8 store
    {4'd8,  3'd2, 10'b0000010100, 2'b10, 3'd1, 1'b0, 1'b0}, // R8 load hit
    {4'd8,  3'd2, 10'b0000010000, 2'b00, 3'd1, 1'b0, 1'b0}, // R8 load miss
    {4'd12, 3'd2, 10'b1000010100, 2'b01, 3'd1, 1'b0, 1'b0}, // R12 wait over filler
    {4'd9,  3'd0, 10'b0000000001, 2'b00, 3'd2, 1'b0, 1'b0}, // R9
    {4'd9,  3'd0, 10'b0000000001, 2'b00, 3'd3, 1'b0, 1'b0}, // R9
    {4'd9,  3'd0, 10'b0000000001, 2'b00, 3'd4, 1'b0, 1'b0}, // R9
    {4'd9,  3'd0, 10'b0000000001, 2'b00, 3'd0, 1'b0, 1'b0}, // R9 fifth closes
    {4'd6,  3'd2, 10'b0000010100, 2'b00, 3'd0, 1'b0, 1'b0}, // R6 store forgotten
    {4'd6,  3'd1, 10'b0100000010, 2'b00, 3'd0, 1'b0, 1'b0}, // R6 alone closes
    {4'd3,  3'd1, 10'b0010000010, 2'b00, 3'd2, 1'b0, 1'b0}, // R3
    {4'd3,  3'd1, 10'b0000000010, 2'b00, 3'd3, 1'b0, 1'b0}, // R3
    {4'd3,  3'd1, 10'b0010000000, 2'b01, 3'd3, 1'b0, 1'b0}, // R3 split at 3
    {4'd10, 3'd1, 10'b0000000011, 2'b00, 3'd0, 1'b0, 1'b0}, // R10 legal pair
    {4'd10, 3'd7, 10'b0000000011, 2'b00, 3'd0, 1'b1, 1'b0}, // R10 illegal pair
    {4'd10, 3'd0, 10'b0000000000, 2'b00, 3'd0, 1'b1, 1'b0}  // R10 sticky
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] u, input logic [9:0] f);
    unit_cls = u;
    {lead_only, alone_only, split_op, wr_cnt, br_cnt,
     is_load, is_store, addr_hit, issue, advance} = f;
  endtask

  initial begin
    #(20 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(3'd0, 10'b0);
    repeat (3) @(negedge clk);
    chk("R1 verdict in reset", verdict, 0);
    chk("R1 slots in reset", slots_used, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 verdict after reset", verdict, 0);
    chk("R1 slots after reset", slots_used, 0);
    chk("R1 error after reset", adv_error, 0);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      drive(v[19:17], v[16:7]);
      @(negedge clk);
      chk($sformatf("R%0d verdict step %0d", v[23:20], i), verdict, v[6:5]);
      chk($sformatf("R%0d slots step %0d", v[23:20], i), slots_used, v[4:2]);
      chk($sformatf("R%0d error step %0d", v[23:20], i), adv_error, v[1]);
    end

    // R1: reset mid-run clears a pending wait verdict, slots and sticky error
    drive(3'd1, 10'b0000000010);
    @(negedge clk);
    drive(3'd1, 10'b1000000000);
    @(negedge clk);
    chk("R2 lead at 1 waits", verdict, 1);
    rst_n = 1'b0;
    #2;
    chk("R1 verdict cleared", verdict, 0);
    chk("R1 slots cleared", slots_used, 0);
    chk("R1 error cleared", adv_error, 0);
    drive(3'd0, 10'b0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: lead-only at slot zero is accepted
    drive(3'd1, 10'b1000000000);
    @(negedge clk);
    chk("R2 lead at 0 joins", verdict, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule